// File: doc/BRIEF.md
# Decimating Trapezoidal Energy Filter

This block shapes a stream of unsigned ADC samples into a trapezoidal energy response. A front-end averager first reduces the sample rate by a power of two, picked by a range setting. The trapezoid is then formed on the reduced-rate stream. Its rise and flat-top lengths are counted in reduced-rate cycles, so one range setting fixes the time step of both lengths. The raw sample period stays the same for every range. Only the averaging factor changes, so all six ranges share one set of hardware.

The shaped value is the sum over the newest `rise` averaged samples minus the sum over an equal window that ends `rise + flat` samples earlier. The output strobe stays low until both windows hold only real data. Illegal length or range settings are pulled to the nearest legal value, and an error flag is raised. Trigger detection, energy capture and baseline removal belong to downstream logic. The range and lengths may change only while the block is held in reset.

Top module: `trap_filter`

## Requirements
- R1: While rst_n is low, out_valid, out_data and cfg_err are all zero.
- R2: For range N (1..6), every 2^N accepted raw samples form one averaged sample equal to their sum shifted right by N bits (floor).
- R3: For averaged sample index n (0-based), out_data = sum of avg[n-R+1..n] minus sum of avg[n-2R-F+1..n-R-F], as a two's-complement value, where R and F are the effective rise and flat lengths.
- R4: The effective rise is rise_len limited to [2, 124]. The effective flat is flat_len limited to [3, 127 - effective rise].
- R5: The effective range is range_sel limited to [1, 6]. cfg_err is 1 from the second cycle after reset whenever any of range_sel, rise_len or flat_len was changed by R4 or R5, and 0 otherwise.
- R6: out_valid stays low for averaged samples with index below 2R+F-1. After that, exactly one output is produced per averaged sample.
- R7: out_valid is a single-cycle pulse. It rises on the cycle after the averager emits a sample, which is two clock edges after the raw sample that completes the group.
- R8: Cycles with in_valid low are ignored, whatever in_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Raw sample strobe |
| in_data | input | DW | Unsigned raw sample |
| range_sel | input | 3 | Averaging range, 2^N samples per step |
| rise_len | input | 7 | Rise length in averaged cycles |
| flat_len | input | 7 | Flat-top length in averaged cycles |
| out_valid | output | 1 | Filter output strobe |
| out_data | output | DW+8 | Signed filter output |
| cfg_err | output | 1 | Setting was clamped |

## Verification
The assertions check the cycle-level invariants on every cycle. They confirm that the clamped setting is always legal, that the averager and output strobes never last two cycles, that every output follows an averager strobe, and that the output magnitude never exceeds rise times full scale. Only the bench's scenarios can show that the values are arithmetically correct. These scenarios are random and gapped streams, a constant input that must shape to zero, a full-scale step, and the clamp corners. The bench compares each output against a model computed from the raw stream, and it also checks that the first output arrives at the exact fill index.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int RISE_MIN = 2;
    localparam int FLAT_MIN = 3;
    localparam int LEN_W    = 7;
    localparam int SEL_W    = 3;

    typedef struct packed {
        logic [SEL_W-1:0] rng;
        logic [LEN_W-1:0] rise;
        logic [LEN_W-1:0] flat;
        logic             err;
    } trap_cfg_t;
endpackage

// File: rtl/trap_cfg_clamp.sv
module trap_cfg_clamp
    import trap_pkg::*;
#(
    parameter int SPAN_MAX  = 127,
    parameter int RANGE_MAX = 6
) (
    input  logic [SEL_W-1:0] range_sel,
    input  logic [LEN_W-1:0] rise_len,
    input  logic [LEN_W-1:0] flat_len,
    output trap_cfg_t        cfg
);
    localparam logic [LEN_W-1:0] RISE_LO = LEN_W'(RISE_MIN);
    localparam logic [LEN_W-1:0] RISE_HI = LEN_W'(SPAN_MAX - FLAT_MIN);
    localparam logic [LEN_W-1:0] FLAT_LO = LEN_W'(FLAT_MIN);
    localparam logic [SEL_W-1:0] RNG_HI  = SEL_W'(RANGE_MAX);

    logic [LEN_W-1:0] flat_hi;

    always_comb begin
        cfg = '0;
        if (range_sel == '0)        cfg.rng = SEL_W'(1);
        else if (range_sel > RNG_HI) cfg.rng = RNG_HI;
        else                          cfg.rng = range_sel;

        if (rise_len < RISE_LO)      cfg.rise = RISE_LO;
        else if (rise_len > RISE_HI) cfg.rise = RISE_HI;
        else                          cfg.rise = rise_len;

        flat_hi = LEN_W'(SPAN_MAX) - cfg.rise;
        if (flat_len < FLAT_LO)      cfg.flat = FLAT_LO;
        else if (flat_len > flat_hi) cfg.flat = flat_hi;
        else                          cfg.flat = flat_len;

        cfg.err = (cfg.rng != range_sel) || (cfg.rise != rise_len) ||
                  (cfg.flat != flat_len);
    end
endmodule

// File: rtl/trap_decim.sv
module trap_decim
    import trap_pkg::*;
#(
    parameter int DW        = 14,
    parameter int RANGE_MAX = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rng,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    output logic             dec_stb,
    output logic [DW-1:0]    dec_data
);
    localparam int AW = DW + RANGE_MAX;
    localparam int CW = RANGE_MAX;

    typedef struct packed {
        logic [AW-1:0] acc;
        logic [CW-1:0] cnt;
        logic          stb;
        logic [DW-1:0] avg;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic [AW-1:0] sum;
    logic [CW-1:0] last_idx;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        last_idx = CW'((1 << rng) - 1);
        sum      = st_q.acc + AW'(in_data);
        if (in_valid) begin
            if (st_q.cnt == last_idx) begin
                st_d.avg = DW'(sum >> rng);
                st_d.stb = 1'b1;
                st_d.acc = '0;
                st_d.cnt = '0;
            end else begin
                st_d.acc = sum;
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dec_stb  = st_q.stb;
    assign dec_data = st_q.avg;

    // R2: a group of at least two raw samples separates averaged strobes
    a_r2_stb_gap: assert property (@(posedge clk) disable iff (!rst_n)
        dec_stb |=> !dec_stb);
endmodule

// File: rtl/trap_delay.sv
module trap_delay #(
    parameter int W     = 14,
    parameter int DEPTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic [PW-1:0]    dly,
    output logic [W-1:0]     dout
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wp_d, wp_q;

    always_comb begin
        wp_d = push ? wp_q + PW'(1) : wp_q;
        dout = mem_q[wp_q - dly];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            wp_q <= wp_d;
            if (push) mem_q[wp_q] <= din;
        end
    end
endmodule

// File: rtl/trap_filter.sv
module trap_filter
    import trap_pkg::*;
#(
    parameter int DW        = 14,
    parameter int RANGE_MAX = 6,
    parameter int SPAN_MAX  = 127
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [DW-1:0]           in_data,
    input  logic [SEL_W-1:0]        range_sel,
    input  logic [LEN_W-1:0]        rise_len,
    input  logic [LEN_W-1:0]        flat_len,
    output logic                    out_valid,
    output logic signed [DW+7:0]    out_data,
    output logic                    cfg_err
);
    localparam int DEPTH = 1 << $clog2(SPAN_MAX + 1);
    localparam int PW    = $clog2(DEPTH);
    localparam int SW    = DW + LEN_W;
    localparam int OW    = SW + 1;
    localparam int FW    = $clog2(2 * SPAN_MAX + 1);

    trap_cfg_t cfg;
    logic          dec_stb;
    logic [DW-1:0] dec_data;
    logic [DW-1:0] old_sample;
    logic [SW-1:0] old_sum;
    logic [SW-1:0] s1_new;
    logic [FW-1:0] need_m1;

    typedef struct packed {
        logic [SW-1:0]        s1;
        logic [FW-1:0]        fill;
        logic                 ov;
        logic signed [OW-1:0] y;
        logic                 err;
    } top_state_t;

    top_state_t st_d, st_q;

    trap_cfg_clamp #(.SPAN_MAX(SPAN_MAX), .RANGE_MAX(RANGE_MAX)) u_clamp (
        .range_sel(range_sel), .rise_len(rise_len), .flat_len(flat_len), .cfg(cfg)
    );

    trap_decim #(.DW(DW), .RANGE_MAX(RANGE_MAX)) u_decim (
        .clk(clk), .rst_n(rst_n), .rng(cfg.rng), .in_valid(in_valid),
        .in_data(in_data), .dec_stb(dec_stb), .dec_data(dec_data)
    );

    trap_delay #(.W(DW), .DEPTH(DEPTH)) u_rise_line (
        .clk(clk), .rst_n(rst_n), .push(dec_stb), .din(dec_data),
        .dly(PW'(cfg.rise)), .dout(old_sample)
    );

    trap_delay #(.W(SW), .DEPTH(DEPTH)) u_sum_line (
        .clk(clk), .rst_n(rst_n), .push(dec_stb), .din(s1_new),
        .dly(PW'(cfg.rise + cfg.flat)), .dout(old_sum)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ov  = 1'b0;
        st_d.err = cfg.err;
        need_m1  = FW'(2 * cfg.rise) + FW'(cfg.flat) - FW'(1);
        s1_new   = st_q.s1 + SW'(dec_data) - SW'(old_sample);
        if (dec_stb) begin
            st_d.s1 = s1_new;
            if (st_q.fill >= need_m1) begin
                st_d.ov = 1'b1;
                st_d.y  = $signed({1'b0, s1_new}) - $signed({1'b0, old_sum});
            end else begin
                st_d.fill = st_q.fill + FW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ov;
    assign out_data  = st_q.y;
    assign cfg_err   = st_q.err;

    // R4: the clamp never hands an illegal setting to the datapath
    a_r4_cfg_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.rise >= LEN_W'(RISE_MIN)) && (cfg.flat >= LEN_W'(FLAT_MIN)) &&
        ({1'b0, cfg.rise} + {1'b0, cfg.flat} <= (LEN_W+1)'(SPAN_MAX)));

    // R5: effective range always inside 1..RANGE_MAX
    a_r5_range_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.rng != '0) && (cfg.rng <= SEL_W'(RANGE_MAX)));

    // R7: output strobe is one cycle wide and follows an averaged sample
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    a_r7_after_decim: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(dec_stb));

    // R3: magnitude bounded by rise times full scale
    logic [OW+LEN_W-1:0] mag, bound;
    always_comb begin
        mag   = (OW+LEN_W)'(out_data[OW-1] ? -out_data : out_data);
        bound = (OW+LEN_W)'(cfg.rise) * (OW+LEN_W)'((1 << DW) - 1);
    end
    a_r3_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mag <= bound));
endmodule

// File: tb/trap_filter_test.sv
module trap_filter_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 14;
    localparam int MAXV = (1 << DW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [2:0] range_sel = 3'd1;
    logic [6:0] rise_len = 7'd2;
    logic [6:0] flat_len = 7'd3;
    logic out_valid;
    logic signed [DW+7:0] out_data;
    logic cfg_err;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit collecting = 0;
    int got[$];
    int raw[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_filter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .range_sel(range_sel), .rise_len(rise_len), .flat_len(flat_len),
        .out_valid(out_valid), .out_data(out_data), .cfg_err(cfg_err)
    );

    always @(negedge clk) if (collecting && out_valid) got.push_back(int'(out_data));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lim(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int pattern(input int kind, input int i, input int total);
        case (kind)
            0: return int'($urandom % (MAXV + 1));
            1: return 5000;
            2: return (i < total / 2) ? MAXV : 0;
            default: return (i * 37) % (MAXV + 1);
        endcase
    endfunction

    task automatic run(input int sel, input int rise, input int flat, input int kind,
                       input int extra);
        int n, r, f, len, need, total, nd;
        int dec[$];
        bit exp_err;
        n = lim(sel, 1, 6);
        r = lim(rise, 2, 124);
        f = lim(flat, 3, 127 - r);
        exp_err = (n != sel) || (r != rise) || (f != flat);
        len = 1 << n;
        need = 2 * r + f;
        total = (need + extra) * len;

        rst_n = 1'b0;
        range_sel = 3'(sel); rise_len = 7'(rise); flat_len = 7'(flat);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 0 && out_data == 0 && cfg_err == 0, "R1",
              int'(out_valid) + int'(cfg_err), 0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check(cfg_err == exp_err, "R4/R5 err flag", int'(cfg_err), int'(exp_err));

        got.delete(); raw.delete();
        collecting = 1;
        for (int i = 0; i < total; i++) begin
            while ($urandom % 4 == 0) begin
                in_valid = 1'b0;
                in_data = DW'($urandom);   // R8: garbage during gaps
                @(negedge clk);
            end
            raw.push_back(pattern(kind, i, total));
            in_valid = 1'b1;
            in_data = DW'(raw[$]);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        collecting = 0;

        // R2: averaged samples
        nd = total / len;
        for (int k = 0; k < nd; k++) begin
            longint s = 0;
            for (int j = 0; j < len; j++) s += raw[k * len + j];
            dec.push_back(int'(s >> n));
        end
        // R6: one output per averaged sample from index need-1
        check(got.size() == nd - need + 1, "R6 output count", got.size(), nd - need + 1);
        for (int k = need - 1; k < nd; k++) begin
            int a = 0, b = 0, idx;
            for (int j = k - r + 1; j <= k; j++) a += dec[j];
            for (int j = k - 2 * r - f + 1; j <= k - r - f; j++) b += dec[j];
            idx = k - need + 1;
            if (idx < got.size())
                check(got[idx] == a - b, "R3 R2 R8 filter value", got[idx], a - b);
        end
        if (kind == 1 && got.size() > 0)
            check(got[got.size() - 1] == 0, "R3 constant input", got[got.size() - 1], 0);
    endtask

    task automatic latency_check();
        int edges;
        // R7: range 1, rise 2, flat 3 -> need 7 averaged samples = 14 raw
        rst_n = 1'b0; range_sel = 3'd1; rise_len = 7'd2; flat_len = 7'd3;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 14; i++) begin
            in_valid = 1'b1; in_data = DW'(100); @(negedge clk);
        end
        in_valid = 1'b0;
        check(out_valid == 0, "R7 not yet after one edge", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1, "R7 valid two edges after group", int'(out_valid), 1);
        @(negedge clk);
        check(out_valid == 0, "R7 single pulse", int'(out_valid), 0);
        edges = 0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        latency_check();
        run(1, 2, 3, 0, 20);
        run(3, 10, 20, 0, 15);
        run(2, 124, 3, 0, 5);
        run(6, 5, 4, 2, 10);
        run(4, 7, 9, 1, 8);
        run(0, 1, 0, 3, 12);
        run(7, 1, 127, 0, 4);
        run(2, 100, 100, 2, 6);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule